// File: doc/BRIEF.md
# Event-Selectable Performance Counter

This block is one performance counter for a core that can complete up to two instructions per clock down two in-order pipes. Every clock the core presents raw, per-pipe strobes and small counts: segment-register writes, executed branches, taken branches, branch target buffer hits, pipeline flushes and their causes, completed instructions, bus activity and write-buffer stalls. An 8-bit select code picks one event, and the counter adds that event's amount for the clock.

There are two kinds of event. Occurrence events add 0, 1 or 2 in a clock, one per pipe or per write. Duration events add one for every clock in which a condition holds. One event is the per-pipe logical OR of "taken branch" and "buffer hit". Software can load any 40-bit value at any time. Counting is gated by an enable, and a change of select code keeps the accumulated total.

Top module: `pmc_counter`

## Requirements
- R1: After reset `count_q` is zero.
- R2: Select 0x0F adds `seg_wr_cnt` (0, 1 or 2) each clock. The encoding 3 is clamped to 2.
- R3: Select 0x12 adds the number of pipes with `br_exec` set, whether or not that branch is taken.
- R4: Select 0x13 adds the number of pipes where `btb_hit` and `br_exec` are both set. A hit on a pipe with no executed branch adds nothing.
- R5: Select 0x14 adds the number of pipes with `br_exec` set and either `br_taken` or `btb_hit` set. A branch that is both taken and a hit counts once.
- R6: Select 0x15 adds 1 when `flush_pulse` is set, unless `flush_serial` or `flush_swint` is set in the same clock.
- R7: Select 0x16 adds the number of set bits of `insn_done` (bit 0 is the first pipe, bit 1 the paired pipe). Bit 0 is ignored while `insn_rep_iter` is set, and both bits are ignored while `core_halted` is set.
- R8: Select 0x17 adds 1 when `insn_done[1]` is set and `core_halted` is clear. Bit 0 has no effect.
- R9: Select 0x18 adds 1 in every clock where any of `bus_active`, `bus_hold`, `addr_hold` or `bus_backoff` is set, and never more than 1.
- R10: Select 0x19 adds 1 in every clock where `wbuf_stall` is set and `wbuf_stall_io` is clear.
- R11: Select codes 0x10, 0x11 and every code not listed above add zero.
- R12: The counter is 40 bits wide and wraps from all ones to zero plus the remainder of the increment.
- R13: When `wr_en` is set, the next `count_q` equals `wr_data`, and any increment in that clock is discarded.
- R14: With `cnt_en` clear the value holds. A change of `evt_sel` keeps the accumulated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counting enable |
| evt_sel | input | 8 | Event select code |
| wr_en | input | 1 | Software load strobe |
| wr_data | input | 40 | Value to load |
| seg_wr_cnt | input | 2 | Segment-register writes this clock |
| br_exec | input | 2 | Branch executed, per pipe |
| br_taken | input | 2 | Branch taken, per pipe |
| btb_hit | input | 2 | Branch target buffer hit, per pipe |
| flush_pulse | input | 1 | Pipeline flush this clock |
| flush_serial | input | 1 | Flush comes from a serializing instruction |
| flush_swint | input | 1 | Flush comes from a software interrupt |
| insn_done | input | 2 | Instruction completed, per pipe |
| insn_rep_iter | input | 1 | Pipe-0 completion is a later repeat iteration |
| core_halted | input | 1 | Core sits in the halt state |
| bus_active | input | 1 | Bus cycle in progress |
| bus_hold | input | 1 | Bus hold acknowledged |
| addr_hold | input | 1 | Address hold in force |
| bus_backoff | input | 1 | Bus back-off in force |
| wbuf_stall | input | 1 | Pipeline stalled on full write buffers |
| wbuf_stall_io | input | 1 | That stall is due to an I/O access |
| count_q | output | 40 | Counter value |

## Verification
A software load and an enabled increment can land in the same clock. The bench provokes this by raising `wr_en` while the selected event is active and counting is enabled, and it expects exactly the loaded value one clock later. The wrap case is also checked: the bench loads all ones and then adds an increment of two, so both the load and the carry out of the top bit are exercised.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int PMC_ISSUE = 2;
  localparam int PMC_INC_W = $clog2(PMC_ISSUE + 1);
  localparam int PMC_SEL_W = 8;

  typedef enum logic [PMC_SEL_W-1:0] {
    SEL_SEG    = 8'h0F,
    SEL_RSV0   = 8'h10,
    SEL_RSV1   = 8'h11,
    SEL_BRANCH = 8'h12,
    SEL_BHIT   = 8'h13,
    SEL_TKHIT  = 8'h14,
    SEL_FLUSH  = 8'h15,
    SEL_INSN   = 8'h16,
    SEL_VINSN  = 8'h17,
    SEL_BUS    = 8'h18,
    SEL_WBSTL  = 8'h19
  } pmc_sel_e;

  typedef struct packed {
    logic [PMC_INC_W-1:0] seg;
    logic [PMC_INC_W-1:0] branch;
    logic [PMC_INC_W-1:0] bhit;
    logic [PMC_INC_W-1:0] tkhit;
    logic [PMC_INC_W-1:0] flush;
    logic [PMC_INC_W-1:0] insn;
    logic [PMC_INC_W-1:0] vinsn;
    logic [PMC_INC_W-1:0] bus;
    logic [PMC_INC_W-1:0] wbstl;
  } pmc_amt_t;

  function automatic logic [PMC_INC_W-1:0] pop_lanes(input logic [PMC_ISSUE-1:0] v);
    logic [PMC_INC_W-1:0] s;
    s = '0;
    for (int i = 0; i < PMC_ISSUE; i++) s = s + PMC_INC_W'(v[i]);
    return s;
  endfunction

  function automatic logic [PMC_INC_W-1:0] clamp_seg(input logic [1:0] c);
    return (c == 2'd3) ? PMC_INC_W'(2) : PMC_INC_W'(c);
  endfunction
endpackage

// File: rtl/pmc_event_qualify.sv
module pmc_event_qualify
  import pmc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           seg_wr_cnt,
  input  logic [PMC_ISSUE-1:0] br_exec,
  input  logic [PMC_ISSUE-1:0] br_taken,
  input  logic [PMC_ISSUE-1:0] btb_hit,
  input  logic                 flush_pulse,
  input  logic                 flush_serial,
  input  logic                 flush_swint,
  input  logic [PMC_ISSUE-1:0] insn_done,
  input  logic                 insn_rep_iter,
  input  logic                 core_halted,
  input  logic                 bus_active,
  input  logic                 bus_hold,
  input  logic                 addr_hold,
  input  logic                 bus_backoff,
  input  logic                 wbuf_stall,
  input  logic                 wbuf_stall_io,
  output pmc_amt_t             amt
);
  logic [PMC_ISSUE-1:0] lane_bhit;
  logic [PMC_ISSUE-1:0] lane_tkhit;
  logic [PMC_ISSUE-1:0] lane_insn;
  logic                 flush_counted;
  logic                 bus_busy;
  logic                 wb_counted;

  for (genvar g = 0; g < PMC_ISSUE; g++) begin : g_lane
    assign lane_bhit[g]  = br_exec[g] & btb_hit[g];
    assign lane_tkhit[g] = br_exec[g] & (br_taken[g] | btb_hit[g]);
    if (g == 0) begin : g_first
      assign lane_insn[g] = insn_done[g] & ~core_halted & ~insn_rep_iter;
    end else begin : g_other
      assign lane_insn[g] = insn_done[g] & ~core_halted;
    end
  end

  assign flush_counted = flush_pulse & ~flush_serial & ~flush_swint;
  assign bus_busy      = bus_active | bus_hold | addr_hold | bus_backoff;
  assign wb_counted    = wbuf_stall & ~wbuf_stall_io;

  always_comb begin
    amt        = '0;
    amt.seg    = clamp_seg(seg_wr_cnt);
    amt.branch = pop_lanes(br_exec);
    amt.bhit   = pop_lanes(lane_bhit);
    amt.tkhit  = pop_lanes(lane_tkhit);
    amt.flush  = PMC_INC_W'(flush_counted);
    amt.insn   = pop_lanes(lane_insn);
    amt.vinsn  = PMC_INC_W'(lane_insn[PMC_ISSUE-1]);
    amt.bus    = PMC_INC_W'(bus_busy);
    amt.wbstl  = PMC_INC_W'(wb_counted);
  end

  // R6
  flush_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_serial || flush_swint) |-> amt.flush == '0);

  // R5
  tkhit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    amt.bhit <= amt.tkhit && amt.tkhit <= amt.branch);

  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_halted |-> (amt.insn == '0 && amt.vinsn == '0));
endmodule

// File: rtl/pmc_event_mux.sv
module pmc_event_mux
  import pmc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PMC_SEL_W-1:0] sel,
  input  pmc_amt_t             amt,
  output logic [PMC_INC_W-1:0] inc
);
  always_comb begin
    case (sel)
      SEL_SEG:    inc = amt.seg;
      SEL_BRANCH: inc = amt.branch;
      SEL_BHIT:   inc = amt.bhit;
      SEL_TKHIT:  inc = amt.tkhit;
      SEL_FLUSH:  inc = amt.flush;
      SEL_INSN:   inc = amt.insn;
      SEL_VINSN:  inc = amt.vinsn;
      SEL_BUS:    inc = amt.bus;
      SEL_WBSTL:  inc = amt.wbstl;
      default:    inc = '0;
    endcase
  end

  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 8'h10 || sel == 8'h11) |-> inc == '0);

  // R9
  duration_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 8'h18 || sel == 8'h19) |-> inc <= PMC_INC_W'(1));
endmodule

// File: rtl/pmc_accum.sv
module pmc_accum
  import pmc_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cnt_en,
  input  logic                 wr_en,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic [PMC_INC_W-1:0] inc,
  output logic [CNT_W-1:0]     count_q
);
  localparam logic [CNT_W-1:0] MAX_STEP = CNT_W'(PMC_ISSUE);

  function automatic logic [CNT_W-1:0] add_wrap(input logic [CNT_W-1:0] c,
                                                input logic [PMC_INC_W-1:0] d);
    return c + CNT_W'(d);
  endfunction

  logic [CNT_W-1:0] count_d;

  always_comb begin
    if (wr_en)       count_d = wr_data;
    else if (cnt_en) count_d = add_wrap(count_q, inc);
    else             count_d = count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  // R13
  wr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> count_q == $past(wr_data));

  // R14
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cnt_en) |=> $stable(count_q));

  // R12
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cnt_en) |=> (count_q - $past(count_q)) <= MAX_STEP);
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter
  import pmc_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [7:0]       evt_sel,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       seg_wr_cnt,
  input  logic [1:0]       br_exec,
  input  logic [1:0]       br_taken,
  input  logic [1:0]       btb_hit,
  input  logic             flush_pulse,
  input  logic             flush_serial,
  input  logic             flush_swint,
  input  logic [1:0]       insn_done,
  input  logic             insn_rep_iter,
  input  logic             core_halted,
  input  logic             bus_active,
  input  logic             bus_hold,
  input  logic             addr_hold,
  input  logic             bus_backoff,
  input  logic             wbuf_stall,
  input  logic             wbuf_stall_io,
  output logic [CNT_W-1:0] count_q
);
  pmc_amt_t             evt_amt;
  logic [PMC_INC_W-1:0] evt_inc;

  pmc_event_qualify u_qualify (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_cnt(seg_wr_cnt), .br_exec(br_exec), .br_taken(br_taken),
    .btb_hit(btb_hit), .flush_pulse(flush_pulse), .flush_serial(flush_serial),
    .flush_swint(flush_swint), .insn_done(insn_done),
    .insn_rep_iter(insn_rep_iter), .core_halted(core_halted),
    .bus_active(bus_active), .bus_hold(bus_hold), .addr_hold(addr_hold),
    .bus_backoff(bus_backoff), .wbuf_stall(wbuf_stall),
    .wbuf_stall_io(wbuf_stall_io), .amt(evt_amt)
  );

  pmc_event_mux u_mux (
    .clk(clk), .rst_n(rst_n), .sel(evt_sel), .amt(evt_amt), .inc(evt_inc)
  );

  pmc_accum #(.CNT_W(CNT_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_data(wr_data), .inc(evt_inc), .count_q(count_q)
  );

  // R2
  seg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_sel == 8'h0F && cnt_en && !wr_en && seg_wr_cnt == 2'd3)
      |=> count_q == $past(count_q) + CNT_W'(2));
endmodule

// File: tb/test_pmc_counter.sv
module test_pmc_counter;
  localparam int W = 40;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } sb_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en, wr_en, flush_pulse, flush_serial, flush_swint;
  logic insn_rep_iter, core_halted, bus_active, bus_hold, addr_hold, bus_backoff;
  logic wbuf_stall, wbuf_stall_io;
  logic [7:0] evt_sel;
  logic [W-1:0] wr_data, count_q;
  logic [1:0] seg_wr_cnt, br_exec, br_taken, btb_hit, insn_done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [W-1:0] model = '0;
  sb_item_t sbq[$];

  always #5 clk = ~clk;

  pmc_counter i_pmc_counter (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .evt_sel(evt_sel),
    .wr_en(wr_en), .wr_data(wr_data), .seg_wr_cnt(seg_wr_cnt),
    .br_exec(br_exec), .br_taken(br_taken), .btb_hit(btb_hit),
    .flush_pulse(flush_pulse), .flush_serial(flush_serial),
    .flush_swint(flush_swint), .insn_done(insn_done),
    .insn_rep_iter(insn_rep_iter), .core_halted(core_halted),
    .bus_active(bus_active), .bus_hold(bus_hold), .addr_hold(addr_hold),
    .bus_backoff(bus_backoff), .wbuf_stall(wbuf_stall),
    .wbuf_stall_io(wbuf_stall_io), .count_q(count_q)
  );

  function automatic int expect_inc();
    int n;
    n = 0;
    if (evt_sel == 8'h0F) n = (seg_wr_cnt > 2'd2) ? 2 : int'(seg_wr_cnt);
    if (evt_sel == 8'h12) n = $countones(br_exec);
    if (evt_sel == 8'h13) n = $countones(br_exec & btb_hit);
    if (evt_sel == 8'h14) n = $countones(br_exec & (br_taken | btb_hit));
    if (evt_sel == 8'h15) n = (flush_pulse && !flush_serial && !flush_swint) ? 1 : 0;
    if (evt_sel == 8'h16 && !core_halted)
      n = int'(insn_done[1]) + ((insn_done[0] && !insn_rep_iter) ? 1 : 0);
    if (evt_sel == 8'h17 && !core_halted) n = int'(insn_done[1]);
    if (evt_sel == 8'h18) n = (bus_active || bus_hold || addr_hold || bus_backoff) ? 1 : 0;
    if (evt_sel == 8'h19) n = (wbuf_stall && !wbuf_stall_io) ? 1 : 0;
    return n;
  endfunction

  task automatic quiet();
    seg_wr_cnt = 0; br_exec = 0; br_taken = 0; btb_hit = 0; insn_done = 0;
    flush_pulse = 0; flush_serial = 0; flush_swint = 0; insn_rep_iter = 0;
    core_halted = 0; bus_active = 0; bus_hold = 0; addr_hold = 0;
    bus_backoff = 0; wbuf_stall = 0; wbuf_stall_io = 0; wr_en = 0;
  endtask

  task automatic all_high();
    seg_wr_cnt = 3; br_exec = 3; br_taken = 3; btb_hit = 3; insn_done = 3;
    flush_pulse = 1; bus_active = 1; bus_hold = 1; addr_hold = 1;
    bus_backoff = 1; wbuf_stall = 1;
  endtask

  // driver: inputs already set after a falling edge; push the expected result
  task automatic step(input string tag);
    sb_item_t it;
    if (wr_en) model = wr_data;
    else if (cnt_en) model = model + W'(expect_inc());
    it.exp = model;
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    quiet();
  endtask

  // monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      sb_item_t it;
      it = sbq.pop_front();
      checks++;
      if (count_q !== it.exp) begin
        errors++;
        $display("FAIL %s: count_q=%h expected=%h", it.tag, count_q, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    quiet();
    cnt_en = 0; evt_sel = 8'h00; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (count_q !== '0) begin
      errors++;
      $display("FAIL R1: count_q=%h expected=0", count_q);
    end

    // R14 disabled: events present but nothing counted
    evt_sel = 8'h16; all_high(); step("R14 disabled");
    cnt_en = 1;

    // R2 segment writes
    evt_sel = 8'h0F; seg_wr_cnt = 1; step("R2 one write");
    seg_wr_cnt = 2; step("R2 privilege change");
    seg_wr_cnt = 3; step("R2 clamp");

    // R3 branches
    evt_sel = 8'h12; br_exec = 2'b11; br_taken = 2'b01; step("R3 both pipes");
    br_exec = 2'b10; step("R3 not taken");
    br_taken = 2'b11; btb_hit = 2'b11; step("R3 no exec");

    // R4 buffer hits
    evt_sel = 8'h13; br_exec = 2'b01; btb_hit = 2'b11; step("R4 exec filter");

    // R5 taken OR hit
    evt_sel = 8'h14; br_exec = 2'b11; br_taken = 2'b01; btb_hit = 2'b11; step("R5 two lanes");
    br_exec = 2'b01; br_taken = 2'b01; btb_hit = 2'b01; step("R5 both once");
    br_exec = 2'b10; btb_hit = 2'b10; step("R5 hit only");

    // R6 flushes
    evt_sel = 8'h15; flush_pulse = 1; step("R6 flush");
    flush_pulse = 1; flush_serial = 1; step("R6 serializing");
    flush_pulse = 1; flush_swint = 1; step("R6 soft interrupt");

    // R7 instructions
    evt_sel = 8'h16; insn_done = 2'b11; step("R7 dual issue");
    insn_done = 2'b11; insn_rep_iter = 1; step("R7 repeat iteration");
    insn_done = 2'b11; core_halted = 1; step("R7 halted");

    // R8 paired pipe
    evt_sel = 8'h17; insn_done = 2'b11; step("R8 paired");
    insn_done = 2'b01; step("R8 first pipe only");

    // R9 bus duration
    evt_sel = 8'h18; bus_active = 1; step("R9 active");
    bus_hold = 1; step("R9 hold");
    addr_hold = 1; step("R9 address hold");
    bus_backoff = 1; step("R9 backoff");
    bus_active = 1; bus_hold = 1; addr_hold = 1; bus_backoff = 1; step("R9 all at once");
    step("R9 idle");

    // R10 write-buffer stall
    evt_sel = 8'h19; wbuf_stall = 1; step("R10 stall");
    wbuf_stall = 1; wbuf_stall_io = 1; step("R10 io stall");

    // R11 reserved and unlisted codes
    evt_sel = 8'h10; all_high(); step("R11 code 10");
    evt_sel = 8'h11; all_high(); step("R11 code 11");
    evt_sel = 8'h00; all_high(); step("R11 code 00");
    evt_sel = 8'hFF; all_high(); step("R11 code FF");

    // R14 select change keeps the value
    evt_sel = 8'h12; step("R14 select change");

    // R13 write wins over an increment
    evt_sel = 8'h16; insn_done = 2'b11; wr_en = 1; wr_data = 40'h12_3456_789A;
    step("R13 write priority");

    // R12 wrap through all ones
    wr_en = 1; wr_data = {W{1'b1}}; step("R12 preload");
    insn_done = 2'b11; step("R12 wrap");
    insn_done = 2'b10; step("R12 after wrap");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule